// File: doc/BRIEF.md
# Serial FIFO Level, Status and Interrupt Unit

This block holds the transmit and receive word queues of a serial controller, together with the logic that reports on them. The processor side loads transmit words and unloads receive words. The shift engine takes transmit words from the other end and deposits the words it receives. Each queue has an occupancy count, and each count is compared against programmable interrupt thresholds and against separate DMA thresholds. The results appear as a status word, a raw interrupt vector, a masked interrupt vector and a single interrupt line.

Overflow and underflow events are sticky. They stay set until software writes a clear command, which can either name one event or clear all of them at once. The threshold and DMA-level registers clamp any value above the last valid level. Software can therefore learn the queue depth by writing large values and reading them back. Dropping the controller enable empties both queues at once.

Configuration uses a simple write strobe with a 3-bit register select and a data word. The stored threshold, DMA-level and mask values are always visible on dedicated read-back outputs.

Top module: `sfx_stat_irq`

## Requirements
- R1: After synchronous reset:
  - both levels, all thresholds, DMA levels, the mask and the DMA enables are zero;
  - status equals 5'b01100;
  - raw interrupts equal 5'b00001;
  - `irq` and both DMA requests are low.
- R2: Each queue delivers words in the order they were accepted. Each level output equals the number of held entries, from 0 to DEPTH. When a queue is empty its head output (`eng_tx_data`, `rx_rdata`) reads zero.
- R3: The status word is assigned as follows:
  - bit 0 follows `busy_in`;
  - bit 1 is transmit full (level = DEPTH);
  - bit 2 is transmit empty;
  - bit 3 is receive empty;
  - bit 4 is receive full.
- R4: A processor push into a full transmit queue is dropped, even when the engine pops in the same cycle. It sets raw bit 1 (transmit overflow), which stays set until cleared.
- R5: A processor pop from an empty receive queue returns zero and sets raw bit 2 (receive underflow). An engine push into a full receive queue is dropped and sets raw bit 3 (receive overflow). Both bits are sticky.
- R6: Raw bit 0 is high while the transmit level is at or below the transmit threshold. Raw bit 4 is high while the receive level is above the receive threshold.
- R7: `irq_masked` equals `irq_raw` AND `irq_mask`, and `irq` is the OR of `irq_masked`.
- R8: Writing select 3 issues a clear command with these data bits:
  - bit 0 clears all sticky bits;
  - bit 1 clears receive underflow;
  - bit 2 clears receive overflow;
  - bit 3 clears transmit overflow.
  An event that occurs in the same cycle as its clear leaves the bit set.
- R9: The register selects are:
  - 0: transmit threshold;
  - 1: receive threshold;
  - 2: mask (data bits 4:0);
  - 4: DMA enables (bit 0 receive, bit 1 transmit);
  - 5: transmit DMA level;
  - 6: receive DMA level.
  For selects 0, 1, 5 and 6, a value above DEPTH-1 is stored as DEPTH-1.
- R10: `tx_dma_req` is high when the transmit DMA enable is set and the transmit level is at or below the transmit DMA level. `rx_dma_req` is high when the receive DMA enable is set and the receive level is above the receive DMA level.
- R11: While `ctl_en` is low, both queues are emptied and all pushes and pops are ignored. Sticky bits and configuration are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable; low empties both queues |
| busy_in | input | 1 | Shift engine busy indication |
| tx_push | input | 1 | Processor pushes a transmit word |
| tx_wdata | input | W | Transmit word from the processor |
| rx_pop | input | 1 | Processor pops a receive word |
| rx_rdata | output | W | Head of the receive queue, zero when empty |
| eng_tx_pop | input | 1 | Engine takes a transmit word |
| eng_tx_data | output | W | Head of the transmit queue, zero when empty |
| eng_rx_push | input | 1 | Engine deposits a receive word |
| eng_rx_data | input | W | Received word from the engine |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | CFG_W | Configuration write data |
| tx_thr | output | CFG_W | Stored transmit threshold |
| rx_thr | output | CFG_W | Stored receive threshold |
| tx_dma_lvl | output | CFG_W | Stored transmit DMA level |
| rx_dma_lvl | output | CFG_W | Stored receive DMA level |
| irq_mask | output | 5 | Stored interrupt mask |
| tx_lvl | output | LVL_W | Transmit queue occupancy |
| rx_lvl | output | LVL_W | Receive queue occupancy |
| status | output | 5 | Status word |
| irq_raw | output | 5 | Raw interrupt vector |
| irq_masked | output | 5 | Masked interrupt vector |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The bench drives each queue into overflow and underflow. It also pushes into a full transmit queue while the engine pops in that same cycle; a design that tested fullness after the pop would accept that word and miss the overflow. Clear commands are issued in the same cycle as a new event of the same kind, which catches a clear that wrongly takes priority. Threshold writes at DEPTH-1, DEPTH and 255 would expose saturation that is off by one or missing. A disable with data in both queues would reveal a flush that leaves stale levels or wipes the sticky bits.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

    typedef enum logic [2:0] {
        SEL_TX_THR  = 3'd0,
        SEL_RX_THR  = 3'd1,
        SEL_MASK    = 3'd2,
        SEL_CLEAR   = 3'd3,
        SEL_DMA_EN  = 3'd4,
        SEL_TX_DLVL = 3'd5,
        SEL_RX_DLVL = 3'd6,
        SEL_NONE    = 3'd7
    } cfg_sel_e;

    typedef struct packed {
        logic rx_full;
        logic rx_empty;
        logic tx_empty;
        logic tx_full;
        logic busy;
    } stat_t;

    typedef struct packed {
        logic rx_above;
        logic rx_ovf;
        logic rx_udf;
        logic tx_ovf;
        logic tx_low;
    } irq_t;

    localparam int IRQ_N = 5;

    // Decode a clear command into {rx_ovf, rx_udf, tx_ovf} clear strobes
    function automatic logic [2:0] clr_decode(input logic [3:0] c);
        logic [2:0] m;
        m[0] = c[0] | c[3];
        m[1] = c[0] | c[1];
        m[2] = c[0] | c[2];
        return m;
    endfunction

endpackage

// File: rtl/sfx_fifo.sv
module sfx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] cnt;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    assign full    = (cnt == LVL_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push & ~full & ~flush;
    assign pop_ok  = pop & ~empty & ~flush;
    assign level   = cnt;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + LVL_W'(1);
                2'b01:   cnt <= cnt - LVL_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/sfx_cfg.sv
module sfx_cfg
    import sfx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [2:0]       sel,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] tx_thr,
    output logic [CFG_W-1:0] rx_thr,
    output logic [CFG_W-1:0] tx_dlvl,
    output logic [CFG_W-1:0] rx_dlvl,
    output logic [IRQ_N-1:0] mask,
    output logic [1:0]       dma_en,
    output logic             clr_we,
    output logic [3:0]       clr_cmd
);
    localparam logic [CFG_W-1:0] MAXV = CFG_W'(DEPTH - 1);

    cfg_sel_e         sel_e;
    logic [CFG_W-1:0] clamped;

    assign sel_e   = cfg_sel_e'(sel);
    assign clamped = (wdata > MAXV) ? MAXV : wdata;
    assign clr_we  = we && (sel_e == SEL_CLEAR);
    assign clr_cmd = wdata[3:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_thr  <= '0;
            rx_thr  <= '0;
            tx_dlvl <= '0;
            rx_dlvl <= '0;
            mask    <= '0;
            dma_en  <= '0;
        end else if (we) begin
            case (sel_e)
                SEL_TX_THR:  tx_thr  <= clamped;
                SEL_RX_THR:  rx_thr  <= clamped;
                SEL_TX_DLVL: tx_dlvl <= clamped;
                SEL_RX_DLVL: rx_dlvl <= clamped;
                SEL_MASK:    mask    <= wdata[IRQ_N-1:0];
                SEL_DMA_EN:  dma_en  <= wdata[1:0];
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/sfx_irq.sv
module sfx_irq
    import sfx_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic [LVL_W-1:0] tx_lvl,
    input  logic [LVL_W-1:0] rx_lvl,
    input  logic             tx_full,
    input  logic             tx_empty,
    input  logic             rx_full,
    input  logic             rx_empty,
    input  logic             tx_ovf_evt,
    input  logic             rx_udf_evt,
    input  logic             rx_ovf_evt,
    input  logic             clr_we,
    input  logic [3:0]       clr_cmd,
    input  logic [IRQ_N-1:0] mask,
    input  logic [1:0]       dma_en,
    input  logic [CFG_W-1:0] tx_thr,
    input  logic [CFG_W-1:0] rx_thr,
    input  logic [CFG_W-1:0] tx_dlvl,
    input  logic [CFG_W-1:0] rx_dlvl,
    output stat_t            stat,
    output irq_t             raw,
    output logic [IRQ_N-1:0] masked,
    output logic             irq,
    output logic             tx_dma_req,
    output logic             rx_dma_req
);
    logic [CFG_W-1:0] tx_x, rx_x;
    logic [2:0]       cm;
    logic             s_txo, s_rxu, s_rxo;

    assign tx_x = CFG_W'(tx_lvl);
    assign rx_x = CFG_W'(rx_lvl);
    assign cm   = clr_we ? clr_decode(clr_cmd) : 3'b000;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_txo <= 1'b0;
            s_rxu <= 1'b0;
            s_rxo <= 1'b0;
        end else begin
            s_txo <= (s_txo & ~cm[0]) | tx_ovf_evt;
            s_rxu <= (s_rxu & ~cm[1]) | rx_udf_evt;
            s_rxo <= (s_rxo & ~cm[2]) | rx_ovf_evt;
        end
    end

    always_comb begin
        stat.busy     = busy;
        stat.tx_full  = tx_full;
        stat.tx_empty = tx_empty;
        stat.rx_empty = rx_empty;
        stat.rx_full  = rx_full;
    end

    always_comb begin
        raw.tx_low   = (tx_x <= tx_thr);
        raw.tx_ovf   = s_txo;
        raw.rx_udf   = s_rxu;
        raw.rx_ovf   = s_rxo;
        raw.rx_above = (rx_x > rx_thr);
    end

    assign masked     = raw & mask;
    assign irq        = |masked;
    assign tx_dma_req = dma_en[1] && (tx_x <= tx_dlvl);
    assign rx_dma_req = dma_en[0] && (rx_x > rx_dlvl);

endmodule

// File: rtl/sfx_stat_irq.sv
module sfx_stat_irq
    import sfx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    parameter int CFG_W = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_en,
    input  logic             busy_in,
    input  logic             tx_push,
    input  logic [W-1:0]     tx_wdata,
    input  logic             rx_pop,
    output logic [W-1:0]     rx_rdata,
    input  logic             eng_tx_pop,
    output logic [W-1:0]     eng_tx_data,
    input  logic             eng_rx_push,
    input  logic [W-1:0]     eng_rx_data,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] tx_thr,
    output logic [CFG_W-1:0] rx_thr,
    output logic [CFG_W-1:0] tx_dma_lvl,
    output logic [CFG_W-1:0] rx_dma_lvl,
    output logic [4:0]       irq_mask,
    output logic [LVL_W-1:0] tx_lvl,
    output logic [LVL_W-1:0] rx_lvl,
    output logic [4:0]       status,
    output logic [4:0]       irq_raw,
    output logic [4:0]       irq_masked,
    output logic             irq,
    output logic             tx_dma_req,
    output logic             rx_dma_req
);
    logic       flush;
    logic       tx_full, tx_empty, rx_full, rx_empty;
    logic       tx_push_g, rx_pop_g, eng_pop_g, eng_push_g;
    logic       clr_we;
    logic [3:0] clr_cmd;
    logic [1:0] dma_en;
    stat_t      stat;
    irq_t       raw;

    assign flush      = ~ctl_en;
    assign tx_push_g  = tx_push & ctl_en;
    assign rx_pop_g   = rx_pop & ctl_en;
    assign eng_pop_g  = eng_tx_pop & ctl_en;
    assign eng_push_g = eng_rx_push & ctl_en;

    sfx_fifo #(.DEPTH(DEPTH), .W(W)) u_txq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(tx_push_g), .wdata(tx_wdata), .pop(eng_pop_g),
        .head(eng_tx_data), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    sfx_fifo #(.DEPTH(DEPTH), .W(W)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(eng_push_g), .wdata(eng_rx_data), .pop(rx_pop_g),
        .head(rx_rdata), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    sfx_cfg #(.DEPTH(DEPTH), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_dlvl(tx_dma_lvl), .rx_dlvl(rx_dma_lvl),
        .mask(irq_mask), .dma_en(dma_en), .clr_we(clr_we), .clr_cmd(clr_cmd)
    );

    sfx_irq #(.LVL_W(LVL_W), .CFG_W(CFG_W)) u_irq (
        .clk(clk), .rst(rst), .busy(busy_in),
        .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .tx_ovf_evt(tx_push_g & tx_full),
        .rx_udf_evt(rx_pop_g & rx_empty),
        .rx_ovf_evt(eng_push_g & rx_full),
        .clr_we(clr_we), .clr_cmd(clr_cmd), .mask(irq_mask), .dma_en(dma_en),
        .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_dlvl(tx_dma_lvl), .rx_dlvl(rx_dma_lvl),
        .stat(stat), .raw(raw), .masked(irq_masked), .irq(irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    assign status  = stat;
    assign irq_raw = raw;

endmodule

// File: rtl/sfx_chk.sv
module sfx_chk #(
    parameter int DEPTH = 16,
    parameter int W     = 16,
    parameter int CFG_W = 8,
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_en,
    input logic             tx_push,
    input logic             rx_pop,
    input logic [W-1:0]     rx_rdata,
    input logic             cfg_we,
    input logic [2:0]       cfg_sel,
    input logic [CFG_W-1:0] tx_thr,
    input logic [CFG_W-1:0] tx_dma_lvl,
    input logic [4:0]       irq_mask,
    input logic [LVL_W-1:0] tx_lvl,
    input logic [LVL_W-1:0] rx_lvl,
    input logic [4:0]       status,
    input logic [4:0]       irq_raw,
    input logic [4:0]       irq_masked,
    input logic             irq,
    input logic             tx_dma_req
);
    // R2
    lvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_lvl <= LVL_W'(DEPTH)) && (rx_lvl <= LVL_W'(DEPTH)));

    // R2
    empty_head_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_lvl == '0) |-> (rx_rdata == '0));

    // R3
    tx_full_flag_chk: assert property (@(posedge clk) disable iff (rst)
        status[1] |-> (tx_lvl == LVL_W'(DEPTH)));

    // R4
    tx_ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && tx_push && tx_lvl == LVL_W'(DEPTH)) |=> irq_raw[1]);

    // R4
    tx_ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_raw[1] && !(cfg_we && cfg_sel == 3'd3)) |=> irq_raw[1]);

    // R5
    rx_udf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_en && rx_pop && rx_lvl == '0) |=> irq_raw[2]);

    // R7
    irq_or_chk: assert property (@(posedge clk) disable iff (rst)
        irq == (|irq_masked));

    // R7
    masked_subset_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_masked & ~irq_raw) == 5'b0) && ((irq_masked & ~irq_mask) == 5'b0));

    // R9
    thr_sat_chk: assert property (@(posedge clk) disable iff (rst)
        tx_thr <= CFG_W'(DEPTH - 1));

    // R10
    tx_dma_lvl_chk: assert property (@(posedge clk) disable iff (rst)
        tx_dma_req |-> (CFG_W'(tx_lvl) <= tx_dma_lvl));

    // R11
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |=> (tx_lvl == '0) && (rx_lvl == '0));

endmodule

bind sfx_stat_irq sfx_chk #(.DEPTH(DEPTH), .W(W), .CFG_W(CFG_W), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .tx_push(tx_push), .rx_pop(rx_pop),
    .rx_rdata(rx_rdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .tx_thr(tx_thr),
    .tx_dma_lvl(tx_dma_lvl), .irq_mask(irq_mask), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
    .status(status), .irq_raw(irq_raw), .irq_masked(irq_masked), .irq(irq),
    .tx_dma_req(tx_dma_req)
);

// File: tb/tb_sfx_stat_irq.sv
`timescale 1ns/1ps
module tb_sfx_stat_irq;
    localparam int D     = 8;
    localparam int W     = 16;
    localparam int CFG_W = 8;
    localparam int LVL_W = $clog2(D + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_en = 1'b0, busy_in = 1'b0;
    logic tx_push = 1'b0, rx_pop = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [W-1:0] tx_wdata = '0, eng_rx_data = '0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sel = 3'd7;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic [W-1:0] rx_rdata, eng_tx_data;
    logic [CFG_W-1:0] tx_thr, rx_thr, tx_dma_lvl, rx_dma_lvl;
    logic [4:0] irq_mask, status, irq_raw, irq_masked;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic irq, tx_dma_req, rx_dma_req;

    always #2 clk = ~clk;

    sfx_stat_irq #(.DEPTH(D), .W(W), .CFG_W(CFG_W)) dut (.*);

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [W-1:0] txq[$], rxq[$];
    int m_txthr, m_rxthr, m_txdl, m_rxdl;
    bit [4:0] m_mask;
    bit [1:0] m_den;
    bit s_txo, s_rxu, s_rxo;

    function automatic int sat(int v);
        return (v > D - 1) ? D - 1 : v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_update();
        bit e_txo, e_rxu, e_rxo, pushv;
        bit [2:0] cm;
        if (rst) begin
            txq.delete(); rxq.delete();
            m_txthr = 0; m_rxthr = 0; m_txdl = 0; m_rxdl = 0;
            m_mask = '0; m_den = '0;
            s_txo = 0; s_rxu = 0; s_rxo = 0;
            return;
        end
        e_txo = 0; e_rxu = 0; e_rxo = 0; cm = '0;
        if (ctl_en) begin
            pushv = 0;
            if (tx_push) begin
                if (txq.size() < D) pushv = 1; else e_txo = 1;
            end
            if (eng_tx_pop && txq.size() > 0) void'(txq.pop_front());
            if (pushv) txq.push_back(tx_wdata);
            pushv = 0;
            if (eng_rx_push) begin
                if (rxq.size() < D) pushv = 1; else e_rxo = 1;
            end
            if (rx_pop) begin
                if (rxq.size() > 0) void'(rxq.pop_front()); else e_rxu = 1;
            end
            if (pushv) rxq.push_back(eng_rx_data);
        end else begin
            txq.delete(); rxq.delete();
        end
        if (cfg_we) begin
            case (cfg_sel)
                3'd0: m_txthr = sat(int'(cfg_wdata));
                3'd1: m_rxthr = sat(int'(cfg_wdata));
                3'd2: m_mask = cfg_wdata[4:0];
                3'd3: begin
                    cm[0] = cfg_wdata[0] | cfg_wdata[3];
                    cm[1] = cfg_wdata[0] | cfg_wdata[1];
                    cm[2] = cfg_wdata[0] | cfg_wdata[2];
                end
                3'd4: m_den = cfg_wdata[1:0];
                3'd5: m_txdl = sat(int'(cfg_wdata));
                3'd6: m_rxdl = sat(int'(cfg_wdata));
                default: ;
            endcase
        end
        s_txo = (s_txo & ~cm[0]) | e_txo;
        s_rxu = (s_rxu & ~cm[1]) | e_rxu;
        s_rxo = (s_rxo & ~cm[2]) | e_rxo;
    endtask

    function automatic bit [4:0] exp_raw();
        return {bit'(rxq.size() > m_rxthr), s_rxo, s_rxu, s_txo, bit'(txq.size() <= m_txthr)};
    endfunction

    task automatic compare_all();
        bit [4:0] er = exp_raw();
        bit [4:0] es = {bit'(rxq.size() == D), bit'(rxq.size() == 0),
                        bit'(txq.size() == 0), bit'(txq.size() == D), busy_in};
        chk("R2 tx_lvl", int'(tx_lvl), txq.size());
        chk("R2 rx_lvl", int'(rx_lvl), rxq.size());
        chk("R2 eng_tx_data", int'(eng_tx_data), txq.size() > 0 ? int'(txq[0]) : 0);
        chk("R5 rx_rdata", int'(rx_rdata), rxq.size() > 0 ? int'(rxq[0]) : 0);
        chk("R3 status", int'(status), int'(es));
        chk("R6 raw_tx_low", int'(irq_raw[0]), int'(er[0]));
        chk("R4 raw_tx_ovf", int'(irq_raw[1]), int'(er[1]));
        chk("R5 raw_rx_udf", int'(irq_raw[2]), int'(er[2]));
        chk("R5 raw_rx_ovf", int'(irq_raw[3]), int'(er[3]));
        chk("R6 raw_rx_above", int'(irq_raw[4]), int'(er[4]));
        chk("R7 irq_masked", int'(irq_masked), int'(er & m_mask));
        chk("R7 irq", int'(irq), int'(|(er & m_mask)));
        chk("R9 tx_thr", int'(tx_thr), m_txthr);
        chk("R9 rx_thr", int'(rx_thr), m_rxthr);
        chk("R9 tx_dma_lvl", int'(tx_dma_lvl), m_txdl);
        chk("R9 rx_dma_lvl", int'(rx_dma_lvl), m_rxdl);
        chk("R9 irq_mask", int'(irq_mask), int'(m_mask));
        chk("R10 tx_dma_req", int'(tx_dma_req), int'(m_den[1] && txq.size() <= m_txdl));
        chk("R10 rx_dma_req", int'(rx_dma_req), int'(m_den[0] && rxq.size() > m_rxdl));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        tx_push = 0; rx_pop = 0; eng_tx_pop = 0; eng_rx_push = 0; cfg_we = 0;
    endtask

    task automatic wr(int sel, int val);
        cfg_we = 1; cfg_sel = 3'(sel); cfg_wdata = CFG_W'(val);
        cyc();
        cfg_we = 0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1 reset state
        chk("R1 status", int'(status), 12);
        chk("R1 irq_raw", int'(irq_raw), 1);
        chk("R1 irq", int'(irq), 0);
        chk("R1 tx_dma_req", int'(tx_dma_req), 0);

        // R9 saturation discovery
        wr(0, 7);   chk("R9 thr at D-1", int'(tx_thr), 7);
        wr(0, 8);   chk("R9 thr at D", int'(tx_thr), 7);
        wr(0, 255); chk("R9 thr 255", int'(tx_thr), 7);
        wr(6, 200); chk("R9 rx dma lvl sat", int'(rx_dma_lvl), 7);
        wr(0, 2); wr(1, 1); wr(2, 31); wr(4, 3); wr(5, 3); wr(6, 2);

        ctl_en = 1;
        cyc();
        // R4 fill transmit queue past full
        for (int i = 0; i < 10; i++) begin
            tx_push = 1; tx_wdata = W'(16'hA000 + i);
            cyc();
        end
        idle();
        cyc();
        chk("R4 tx held at depth", int'(tx_lvl), D);
        chk("R4 tx ovf sticky", int'(irq_raw[1]), 1);
        // R4 push to full with concurrent engine pop: dropped
        s_txo = s_txo; // model already tracks
        tx_push = 1; tx_wdata = 16'hBEEF; eng_tx_pop = 1;
        cyc();
        idle();
        chk("R4 push on full with pop dropped", int'(tx_lvl), D - 1);
        // drain transmit queue in order (R2)
        for (int i = 0; i < 9; i++) begin
            eng_tx_pop = 1; cyc();
        end
        idle(); cyc();
        chk("R2 tx drained", int'(tx_lvl), 0);

        // R5 receive overflow and underflow
        for (int i = 0; i < 10; i++) begin
            eng_rx_push = 1; eng_rx_data = W'(16'h5000 + i * 3);
            cyc();
        end
        idle();
        for (int i = 0; i < 10; i++) begin
            rx_pop = 1; cyc();
        end
        idle(); cyc();
        chk("R5 rx udf set", int'(irq_raw[2]), 1);
        chk("R5 rx ovf set", int'(irq_raw[3]), 1);

        // R8 selective clears
        wr(3, 4'b0010);
        chk("R8 clr udf only", int'(irq_raw[3:1]), 3'b101);
        wr(3, 4'b1000);
        chk("R8 clr txo only", int'(irq_raw[3:1]), 3'b100);
        // event coinciding with its own clear keeps the bit
        rx_pop = 1; cfg_we = 1; cfg_sel = 3'd3; cfg_wdata = 8'h02;
        cyc();
        idle();
        chk("R8 set wins over clear", int'(irq_raw[2]), 1);
        wr(3, 4'b0001);
        chk("R8 clear all", int'(irq_raw[3:1]), 0);

        // R11 disable with data and a pending sticky bit
        for (int i = 0; i < 3; i++) begin
            tx_push = 1; tx_wdata = W'(i + 1); eng_rx_push = 1; eng_rx_data = W'(i + 7);
            cyc();
        end
        idle();
        rx_pop = 1; cyc(); rx_pop = 1; cyc(); rx_pop = 1; cyc(); rx_pop = 1; cyc();
        idle();
        ctl_en = 0; tx_push = 1; eng_rx_push = 1;
        cyc(); cyc();
        idle();
        chk("R11 tx flushed", int'(tx_lvl), 0);
        chk("R11 rx flushed", int'(rx_lvl), 0);
        chk("R11 sticky kept", int'(irq_raw[2]), 1);
        chk("R11 cfg kept", int'(rx_thr), 1);
        rx_pop = 1; cyc(); idle();
        chk("R11 pop ignored while off", int'(irq_raw[2]), 1);
        ctl_en = 1;
        cyc();

        // mixed traffic, all outputs compared each cycle
        for (int i = 0; i < 1500; i++) begin
            tx_push     = ($urandom_range(0, 9) < 5);
            tx_wdata    = W'($urandom);
            eng_tx_pop  = ($urandom_range(0, 9) < 4);
            eng_rx_push = ($urandom_range(0, 9) < 4);
            eng_rx_data = W'($urandom);
            rx_pop      = ($urandom_range(0, 9) < 5);
            busy_in     = ($urandom_range(0, 1) == 1);
            ctl_en      = ($urandom_range(0, 19) != 0);
            cfg_we      = ($urandom_range(0, 9) == 0);
            cfg_sel     = 3'($urandom_range(0, 7));
            cfg_wdata   = CFG_W'($urandom_range(0, 12));
            cyc();
        end
        idle();
        busy_in = 1; cyc();
        chk("R3 busy bit", int'(status[0]), 1);
        busy_in = 0; cyc();
        chk("R3 busy bit low", int'(status[0]), 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule